// File: doc/BRIEF.md
# PCI Outbound Memory Window Translator

This block converts a CPU-side access into a PCI bus address. The CPU side names one of four apertures: three memory apertures, each moved around PCI memory space by its own base register, and one I/O aperture pinned to PCI I/O address zero. It also gives the byte offset of the access inside that aperture. One cycle later the block returns the PCI address, or it raises a range flag when the offset lies outside the aperture.

Software sets up the translation through a small register file. It holds three window-base registers, three auxiliary map registers, an identity register and a flags register. Every register is reached only by 32-bit accesses. The parameter `MAP_STYLE` chooses how a window-base register is read, and it also fixes the three aperture sizes:
- **Nibble style (0).** Bits [3:0] of the register become PCI address bits [31:28].
- **Masked style (1).** The register value, with every bit below the aperture size cleared, is the base.

Top module: `pcixl_xlate`

## Requirements
- R1: Reset is synchronous and active high. For the cycle after reset, `out_valid` is 0, `reg_err` is 0 and `reg_rdata` is 0. Afterwards every register reads back as 0.
- R2: With `MAP_STYLE` 0, a memory aperture result is `{wbase[3:0], 28'b0} + offset`, truncated to 32 bits.
- R3: With `MAP_STYLE` 1, a memory aperture result is `(wbase & ~(size-1)) + offset`.
- R4: The aperture sizes for `xlt_sel` 0, 1 and 2 are:
  - style 0: 0x0C000000, 0x10000000 and 0x10000000 bytes;
  - style 1: 0x01000000, 0x04000000 and 0x08000000 bytes.

  An offset equal to or above the size sets `out_range_err` and drives `out_addr` to 0.
- R5: `xlt_sel` 3 is the I/O aperture. It is 0x100000 bytes in both styles and its result equals the offset. An offset at or past 0x100000 is out of range.
- R6: A request sampled at clock edge N produces `out_valid` = 1, with its result, after edge N+1. A cycle with no request produces `out_valid` = 0.
- R7: A window-base write is used by requests sampled at later edges. A request sampled at the same edge as the write uses the previous base.
- R8: Register map, in bytes:
  - window bases at 0x00, 0x04 and 0x08, where window index = (offset − 0x00) / 4;
  - auxiliary maps at 0x10, 0x14 and 0x18;
  - identity at 0x20;
  - flags at 0x24.

  A read (`reg_write` 0) returns the last value written, on `reg_rdata`, after the next edge.
- R9: An access with `reg_size` other than 4 sets `reg_err` after the next edge. It changes no register, and a read of this kind returns 0.
- R10: An access to an offset that is not in the map, or is not word aligned, sets `reg_err`. It changes nothing, and a read of this kind returns 0.
- R11: A write to one window-base register changes the translation of that window only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_size | input | 3 | Access width in bytes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the access |
| reg_err | output | 1 | Bad width or bad offset, one cycle after the access |
| xlt_valid | input | 1 | Translation request strobe |
| xlt_sel | input | 2 | Aperture: 0..2 memory, 3 I/O |
| xlt_offset | input | 32 | Byte offset within the aperture |
| out_valid | output | 1 | Translation result valid |
| out_addr | output | 32 | Translated PCI address |
| out_range_err | output | 1 | Offset was outside the aperture |

## Verification
A window-base write and a translation through that same window can be sampled at one clock edge. The bench provokes this by driving both strobes in the same cycle, so that the same-cycle request must use the old base and the request in the next cycle must use the new one. Both styles are instantiated side by side on the same stimulus, and each result is judged against a queue of expected addresses. The bench computes those addresses from the size table and the base formulas.

// File: rtl/pcixl_pkg.sv
package pcixl_pkg;

    localparam int WORD_W      = 32;
    localparam int REG_AW      = 12;
    localparam int NUM_MEM_WIN = 3;
    localparam int IDX_W       = $clog2(NUM_MEM_WIN + 1);

    localparam int STYLE_NIBBLE = 0;
    localparam int STYLE_MASKED = 1;

    localparam logic [WORD_W-1:0] IO_SIZE = 32'h0010_0000;

    localparam logic [REG_AW-1:0] OFS_WBASE0 = 12'h000;
    localparam logic [REG_AW-1:0] OFS_AUX0   = 12'h010;
    localparam logic [REG_AW-1:0] OFS_IDENT  = 12'h020;
    localparam logic [REG_AW-1:0] OFS_FLAGS  = 12'h024;
    localparam logic [2:0]        ACC_BYTES  = 3'd4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        AP_MEM0 = 2'd0,
        AP_MEM1 = 2'd1,
        AP_MEM2 = 2'd2,
        AP_IO   = 2'd3
    } aperture_e;

    typedef enum logic [1:0] {
        RK_WBASE,
        RK_AUX,
        RK_IDENT,
        RK_FLAGS
    } reg_kind_e;

    typedef struct packed {
        logic             hit;
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_dec_t;

    typedef struct packed {
        logic  valid;
        logic  range_err;
        word_t addr;
    } xlt_res_t;

    function automatic word_t win_size(int style, int idx);
        word_t sz;
        if (style == STYLE_MASKED) begin
            case (idx)
                0:       sz = 32'h0100_0000;
                1:       sz = 32'h0400_0000;
                default: sz = 32'h0800_0000;
            endcase
        end else begin
            case (idx)
                0:       sz = 32'h0C00_0000;
                default: sz = 32'h1000_0000;
            endcase
        end
        return sz;
    endfunction

    function automatic word_t win_base(int style, word_t wbase, word_t size);
        word_t b;
        if (style == STYLE_MASKED) b = wbase & ~(size - 32'd1);
        else                       b = {wbase[3:0], 28'b0};
        return b;
    endfunction

    function automatic reg_dec_t decode_offset(logic [REG_AW-1:0] ofs);
        reg_dec_t d;
        logic [REG_AW-1:0] rel;
        d.hit  = 1'b0;
        d.kind = RK_WBASE;
        d.idx  = '0;
        rel    = '0;
        if (ofs[1:0] == 2'b00) begin
            if (ofs >= OFS_WBASE0 &&
                ofs < OFS_WBASE0 + REG_AW'(4 * NUM_MEM_WIN)) begin
                rel    = ofs - OFS_WBASE0;
                d.hit  = 1'b1;
                d.kind = RK_WBASE;
                d.idx  = rel[IDX_W+1:2];
            end else if (ofs >= OFS_AUX0 &&
                         ofs < OFS_AUX0 + REG_AW'(4 * NUM_MEM_WIN)) begin
                rel    = ofs - OFS_AUX0;
                d.hit  = 1'b1;
                d.kind = RK_AUX;
                d.idx  = rel[IDX_W+1:2];
            end else if (ofs == OFS_IDENT) begin
                d.hit  = 1'b1;
                d.kind = RK_IDENT;
            end else if (ofs == OFS_FLAGS) begin
                d.hit  = 1'b1;
                d.kind = RK_FLAGS;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/pcixl_regfile.sv
module pcixl_regfile
    import pcixl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              reg_valid,
    input  logic                              reg_write,
    input  logic [REG_AW-1:0]                 reg_addr,
    input  logic [2:0]                        reg_size,
    input  word_t                             reg_wdata,
    output word_t                             reg_rdata,
    output logic                              reg_err,
    output logic [NUM_MEM_WIN-1:0][WORD_W-1:0] wbase_q
);

    logic [NUM_MEM_WIN-1:0][WORD_W-1:0] aux_q;
    word_t    ident_q;
    word_t    flags_q;
    reg_dec_t dec;
    logic     acc_ok;
    word_t    rd_mux;

    assign dec    = decode_offset(reg_addr);
    assign acc_ok = dec.hit && (reg_size == ACC_BYTES);

    always_comb begin
        rd_mux = '0;
        case (dec.kind)
            RK_WBASE: if (int'(dec.idx) < NUM_MEM_WIN) rd_mux = wbase_q[dec.idx];
            RK_AUX:   if (int'(dec.idx) < NUM_MEM_WIN) rd_mux = aux_q[dec.idx];
            RK_IDENT: rd_mux = ident_q;
            RK_FLAGS: rd_mux = flags_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbase_q   <= '0;
            aux_q     <= '0;
            ident_q   <= '0;
            flags_q   <= '0;
            reg_rdata <= '0;
            reg_err   <= 1'b0;
        end else begin
            reg_err   <= 1'b0;
            reg_rdata <= '0;
            if (reg_valid) begin
                reg_err <= !acc_ok;
                if (acc_ok && reg_write) begin
                    case (dec.kind)
                        RK_WBASE: if (int'(dec.idx) < NUM_MEM_WIN) wbase_q[dec.idx] <= reg_wdata;
                        RK_AUX:   if (int'(dec.idx) < NUM_MEM_WIN) aux_q[dec.idx]   <= reg_wdata;
                        RK_IDENT: ident_q <= reg_wdata;
                        RK_FLAGS: flags_q <= reg_wdata;
                        default:  ;
                    endcase
                end
                if (acc_ok && !reg_write) reg_rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/pcixl_mem_window.sv
module pcixl_mem_window
    import pcixl_pkg::*;
#(
    parameter int MAP_STYLE = STYLE_NIBBLE,
    parameter int WIN_IDX   = 0
) (
    input  word_t wbase,
    input  word_t offset,
    output word_t pci_addr,
    output logic  in_range
);

    localparam word_t SIZE = win_size(MAP_STYLE, WIN_IDX);

    word_t base;

    assign base     = win_base(MAP_STYLE, wbase, SIZE);
    assign in_range = offset < SIZE;
    assign pci_addr = base + offset;

endmodule

// File: rtl/pcixl_xlate.sv
module pcixl_xlate
    import pcixl_pkg::*;
#(
    parameter int MAP_STYLE = STYLE_NIBBLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [2:0]        reg_size,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              reg_err,
    input  logic              xlt_valid,
    input  logic [1:0]        xlt_sel,
    input  logic [WORD_W-1:0] xlt_offset,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_addr,
    output logic              out_range_err
);

    logic [NUM_MEM_WIN-1:0][WORD_W-1:0] wbase_q;
    logic [NUM_MEM_WIN-1:0][WORD_W-1:0] win_addr;
    logic [NUM_MEM_WIN-1:0]             win_ok;
    xlt_res_t                           res_d;
    xlt_res_t                           res_q;
    aperture_e                          sel;

    pcixl_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_size  (reg_size),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .wbase_q   (wbase_q)
    );

    for (genvar g = 0; g < NUM_MEM_WIN; g++) begin : g_win
        pcixl_mem_window #(
            .MAP_STYLE (MAP_STYLE),
            .WIN_IDX   (g)
        ) u_win (
            .wbase    (wbase_q[g]),
            .offset   (xlt_offset),
            .pci_addr (win_addr[g]),
            .in_range (win_ok[g])
        );
    end

    assign sel = aperture_e'(xlt_sel);

    always_comb begin
        res_d.valid     = xlt_valid;
        res_d.range_err = 1'b0;
        res_d.addr      = '0;
        case (sel)
            AP_IO: begin
                res_d.range_err = !(xlt_offset < IO_SIZE);
                res_d.addr      = xlt_offset;
            end
            default: begin
                res_d.range_err = !win_ok[xlt_sel];
                res_d.addr      = win_addr[xlt_sel];
            end
        endcase
        if (res_d.range_err || !xlt_valid) res_d.addr = '0;
        if (!xlt_valid) res_d.range_err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_valid     = res_q.valid;
    assign out_addr      = res_q.addr;
    assign out_range_err = res_q.range_err;

endmodule

// File: rtl/pcixl_xlate_chk.sv
module pcixl_xlate_chk
    import pcixl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_valid,
    input logic [2:0]        reg_size,
    input logic              reg_err,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              xlt_valid,
    input logic [1:0]        xlt_sel,
    input logic [WORD_W-1:0] xlt_offset,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_addr,
    input logic              out_range_err
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !reg_err && reg_rdata == '0));

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
        xlt_valid |=> out_valid);

    a_r6_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !xlt_valid |=> !out_valid);

    a_r4_range_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_range_err) |-> out_addr == '0);

    a_r5_io_identity: assert property (@(posedge clk) disable iff (rst)
        (xlt_valid && xlt_sel == 2'd3 && xlt_offset < IO_SIZE)
        |=> (!out_range_err && out_addr == $past(xlt_offset)));

    a_r5_io_limit: assert property (@(posedge clk) disable iff (rst)
        (xlt_valid && xlt_sel == 2'd3 && !(xlt_offset < IO_SIZE)) |=> out_range_err);

    a_r9_bad_width: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_size != ACC_BYTES) |=> (reg_err && reg_rdata == '0));

endmodule

bind pcixl_xlate pcixl_xlate_chk u_chk (.*);

// File: tb/tb_pcixl_xlate.sv
module tb_pcixl_xlate;
    import pcixl_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [2:0]  reg_size = 3'd4;
    logic [31:0] reg_wdata = '0;
    logic        xlt_valid = 1'b0;
    logic [1:0]  xlt_sel = '0;
    logic [31:0] xlt_offset = '0;

    logic [31:0] rd0, rd1, ad0, ad1;
    logic        er0, er1, ov0, ov1, re0, re1;

    int n_run = 0, n_fail = 0;
    logic [31:0] shadow [3] = '{32'h0, 32'h0, 32'h0};

    typedef struct {
        logic        e0;
        logic [31:0] a0;
        logic        e1;
        logic [31:0] a1;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    pcixl_xlate #(.MAP_STYLE(0)) dut (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(rd0), .reg_err(er0), .xlt_valid(xlt_valid), .xlt_sel(xlt_sel),
        .xlt_offset(xlt_offset), .out_valid(ov0), .out_addr(ad0), .out_range_err(re0));

    pcixl_xlate #(.MAP_STYLE(1)) dut_m (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(rd1), .reg_err(er1), .xlt_valid(xlt_valid), .xlt_sel(xlt_sel),
        .xlt_offset(xlt_offset), .out_valid(ov1), .out_addr(ad1), .out_range_err(re1));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] size_of(int style, int sel);
        if (sel == 3) return 32'h0010_0000;
        if (style == 1) return (sel == 0) ? 32'h0100_0000 : (sel == 1) ? 32'h0400_0000 : 32'h0800_0000;
        return (sel == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    endfunction

    function automatic logic [32:0] model(int style, int sel, logic [31:0] off);
        logic [31:0] sz, base;
        sz = size_of(style, sel);
        if (off >= sz) return {1'b1, 32'h0};
        if (sel == 3) base = 32'h0;
        else if (style == 1) base = shadow[sel] & ~(sz - 1);
        else base = {shadow[sel][3:0], 28'h0};
        return {1'b0, base + off};
    endfunction

    function automatic exp_t make_exp(int sel, logic [31:0] off, string req);
        exp_t e;
        logic [32:0] m0, m1;
        m0 = model(0, sel, off);
        m1 = model(1, sel, off);
        e.e0 = m0[32]; e.a0 = m0[31:0];
        e.e1 = m1[32]; e.a1 = m1[31:0];
        e.req = req;
        return e;
    endfunction

    // monitor: pops one expected item per result
    always @(posedge clk) begin
        #1;
        if (!rst && (ov0 || ov1)) begin
            exp_t e;
            if (sb.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R6: unexpected result actual %h expected none", ad0);
            end else begin
                e = sb.pop_front();
                chk({e.req, " valid"}, {30'b0, ov1, ov0}, 32'h3);
                chk({e.req, " style0 addr"}, ad0, e.a0);
                chk({e.req, " style0 range"}, {31'b0, re0}, {31'b0, e.e0});
                chk({e.req, " style1 addr"}, ad1, e.a1);
                chk({e.req, " style1 range"}, {31'b0, re1}, {31'b0, e.e1});
            end
        end
    end

    task automatic xlt(int sel, logic [31:0] off, string req);
        @(negedge clk);
        xlt_valid = 1'b1; xlt_sel = 2'(sel); xlt_offset = off;
        sb.push_back(make_exp(sel, off, req));
        @(posedge clk); #1;
        xlt_valid = 1'b0;
    endtask

    task automatic reg_acc(logic wr, logic [11:0] a, logic [2:0] sz, logic [31:0] wd,
                           logic [31:0] exp_rd, logic exp_err, string req);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_size = sz; reg_wdata = wd;
        if (wr && !exp_err && a < 12'h00C) shadow[a[3:2]] = wd;
        @(posedge clk); #1;
        reg_valid = 1'b0;
        chk({req, " err"}, {30'b0, er1, er0}, {30'b0, exp_err, exp_err});
        if (!wr) begin
            chk({req, " rdata0"}, rd0, exp_rd);
            chk({req, " rdata1"}, rd1, exp_rd);
        end
    endtask

    // R7: write and translation presented in the same cycle
    task automatic write_and_xlt(int idx, logic [31:0] wd, int sel, logic [31:0] off);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 12'(idx * 4); reg_size = 3'd4; reg_wdata = wd;
        xlt_valid = 1'b1; xlt_sel = 2'(sel); xlt_offset = off;
        sb.push_back(make_exp(sel, off, "R7 same-cycle old base"));
        shadow[idx] = wd;
        @(posedge clk); #1;
        reg_valid = 1'b0; xlt_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out_valid low in reset", {31'b0, ov0 | ov1}, 32'h0);
        @(negedge clk); rst = 1'b0;
        shadow = '{32'h0, 32'h0, 32'h0};
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] all_regs [8] = '{12'h000, 12'h004, 12'h008, 12'h010,
                                      12'h014, 12'h018, 12'h020, 12'h024};
        do_reset();
        foreach (all_regs[i]) reg_acc(1'b0, all_regs[i], 3'd4, 0, 32'h0, 1'b0, "R1 reset value");

        xlt(0, 32'h0000_0100, "R6 first translation");

        reg_acc(1'b1, 12'h000, 3'd4, 32'h1234_5678, 0, 1'b0, "R8 write wbase0");
        reg_acc(1'b0, 12'h000, 3'd4, 0, 32'h1234_5678, 1'b0, "R8 read wbase0");
        xlt(0, 32'h00AB_CDEF, "R2 R3 window0");

        reg_acc(1'b1, 12'h004, 3'd4, 32'hFFFF_FFF3, 0, 1'b0, "R8 write wbase1");
        xlt(1, 32'h03FF_FFFF, "R3 window1 last byte");
        xlt(1, 32'h0400_0000, "R4 window1 size edge");
        xlt(0, 32'h0C00_0000, "R4 window0 at size");
        xlt(0, 32'h0BFF_FFFF, "R4 window0 below size");
        xlt(2, 32'h0FFF_FFFF, "R11 window2 untouched");
        xlt(3, 32'h000F_FFFF, "R5 io last byte");
        xlt(3, 32'h0010_0000, "R5 io at size");
        // back-to-back requests
        xlt(1, 32'h0000_0010, "R6 back-to-back a");
        xlt(2, 32'h0000_0020, "R6 back-to-back b");

        write_and_xlt(2, 32'h2800_0009, 2, 32'h0000_0010);
        xlt(2, 32'h0000_0010, "R7 next-cycle new base");
        xlt(0, 32'h0000_0040, "R11 window0 after window2 write");

        reg_acc(1'b1, 12'h014, 3'd4, 32'hA5A5_0001, 0, 1'b0, "R8 write aux1");
        reg_acc(1'b1, 12'h020, 3'd4, 32'hCAFE_0000, 0, 1'b0, "R8 write ident");
        reg_acc(1'b1, 12'h024, 3'd4, 32'h0000_0003, 0, 1'b0, "R8 write flags");
        reg_acc(1'b0, 12'h014, 3'd4, 0, 32'hA5A5_0001, 1'b0, "R8 read aux1");
        reg_acc(1'b0, 12'h010, 3'd4, 0, 32'h0, 1'b0, "R8 read aux0");
        reg_acc(1'b0, 12'h020, 3'd4, 0, 32'hCAFE_0000, 1'b0, "R8 read ident");
        reg_acc(1'b0, 12'h024, 3'd4, 0, 32'h0000_0003, 1'b0, "R8 read flags");

        reg_acc(1'b1, 12'h000, 3'd2, 32'hDEAD_BEEF, 0, 1'b1, "R9 half-width write");
        reg_acc(1'b0, 12'h000, 3'd1, 0, 32'h0, 1'b1, "R9 byte read");
        reg_acc(1'b0, 12'h000, 3'd4, 0, 32'h1234_5678, 1'b0, "R9 wbase0 unchanged");

        reg_acc(1'b1, 12'h00C, 3'd4, 32'h0000_0007, 0, 1'b1, "R10 gap write");
        reg_acc(1'b0, 12'h00C, 3'd4, 0, 32'h0, 1'b1, "R10 gap read");
        reg_acc(1'b1, 12'h002, 3'd4, 32'hFFFF_FFFF, 0, 1'b1, "R10 unaligned write");
        reg_acc(1'b0, 12'h000, 3'd4, 0, 32'h1234_5678, 1'b0, "R10 wbase0 unchanged");
        xlt(0, 32'h0000_0004, "R10 translation unchanged");

        do_reset();
        reg_acc(1'b0, 12'h008, 3'd4, 0, 32'h0, 1'b0, "R1 wbase2 cleared");
        reg_acc(1'b0, 12'h020, 3'd4, 0, 32'h0, 1'b0, "R1 ident cleared");
        xlt(2, 32'h0000_0010, "R1 base cleared after reset");

        repeat (3) @(posedge clk);
        #1;
        chk("R6 scoreboard drained", sb.size(), 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule